// File: doc/BRIEF.md
# Double-Precision Funnel Shift Unit

This unit performs a 64-bit double-precision shift in either direction. A destination word and a source word are treated as one wide value, and the shift moves bits out of the source into the vacated end of the destination instead of filling it with zeros. The result is the destination-sized window of that wide shift. Alongside the result, the unit computes the new carry, overflow, zero, sign and parity flags, and passes the auxiliary-carry flag through unchanged.

The shift amount is taken either from an immediate field or from a count-register value, selected per operation, and only its low six bits count. When the masked amount is zero, the operation does nothing: the write-enable stays low and every flag comes back exactly as it went in. A start strobe launches one operation. Its result, flags and write-enable appear one clock later, together with a single-cycle done pulse.

Top module: `dfs_unit`

## Requirements
- R1: The amount comes from `reg_cnt_i` when `cnt_from_reg_i` is 1 and from `imm_cnt_i` when it is 0; only bits [5:0] of the selected value are used, so 64 acts as 0 and 65 (0x41) acts as 1.
- R2: With a masked amount of zero, `wr_en_o` stays 0, `result_o` equals `dst_i`, and all six flag outputs equal the six flag inputs.
- R3: With `dir_right_i` = 0 (left) and amount n in 1..63, `result_o` = (dst << n) | (src >> (64 - n)).
- R4: With `dir_right_i` = 1 (right) and amount n in 1..63, `result_o` = (src << (64 - n)) | (dst >> n).
- R5: `carry_o` is destination bit (64 - n) for a left shift and destination bit (n - 1) for a right shift.
- R6: For n = 1, `ovf_o` is 1 exactly when bit 63 of the result differs from bit 63 of the destination; for any other non-zero n, `ovf_o` equals `ovf_i`.
- R7: For a non-zero amount, `zero_o` is 1 exactly when the result is all zeros, and `sign_o` equals result bit 63.
- R8: For a non-zero amount, `parity_o` is 1 exactly when result bits [7:0] hold an even number of ones.
- R9: `aux_o` equals `aux_i` for every operation.
- R10: `done_o` is 1 in the cycle after a start strobe and only then; `wr_en_o` can be 1 only together with `done_o`; between operations the result and flag outputs hold their last values.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches one operation |
| dir_right_i | input | 1 | 0 = left funnel shift, 1 = right funnel shift |
| cnt_from_reg_i | input | 1 | 1 = amount from count register, 0 = from immediate |
| imm_cnt_i | input | 8 | Immediate shift amount |
| reg_cnt_i | input | 8 | Count-register shift amount |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand supplying the shifted-in bits |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| zero_i | input | 1 | Incoming zero flag |
| sign_i | input | 1 | Incoming sign flag |
| parity_i | input | 1 | Incoming parity flag |
| aux_i | input | 1 | Incoming auxiliary-carry flag |
| result_o | output | 64 | Shift result |
| wr_en_o | output | 1 | Write back the result (0 for a zero amount) |
| carry_o | output | 1 | Updated carry flag |
| ovf_o | output | 1 | Updated overflow flag |
| zero_o | output | 1 | Updated zero flag |
| sign_o | output | 1 | Updated sign flag |
| parity_o | output | 1 | Updated parity flag |
| aux_o | output | 1 | Auxiliary-carry flag, passed through |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a six-bit effective amount, 8-bit count fields and an 8-bit parity window. With these values both ends of the amount range can be driven. Amounts 1 and 63 exercise the overflow rule and the carry indices at the word edges. Count fields of 64 and 65 show that the upper bits are masked off. Operands are chosen so that results become all-zero, negative, and of odd and even low-byte parity.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dfs_dir_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic zf;
    logic sf;
    logic pf;
    logic af;
  } dfs_flags_t;

endpackage

// File: rtl/dfs_count_sel.sv
module dfs_count_sel #(
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 6
) (
  input  logic                cnt_from_reg_i,
  input  logic [CNT_IN_W-1:0] imm_cnt_i,
  input  logic [CNT_IN_W-1:0] reg_cnt_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                cnt_zero_o,
  output logic                cnt_one_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_IN_W-1:0] raw;
  logic                unused_hi;

  always_comb begin
    raw = cnt_from_reg_i ? reg_cnt_i : imm_cnt_i;
  end

  // The upper bits of the selected count never take part in the shift.
  assign unused_hi  = ^raw[CNT_IN_W-1:CNT_W];
  assign cnt_o      = raw[CNT_W-1:0];
  assign cnt_zero_o = (cnt_o == '0);
  assign cnt_one_o  = (cnt_o == ONE);
endmodule

// File: rtl/dfs_funnel.sv
module dfs_funnel #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 6
) (
  input  logic              dir_right_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  import dfs_pkg::*;

  localparam int          WIDE_W = 2 * DATA_W;
  localparam logic [CNT_W:0] FULL = DATA_W[CNT_W:0];

  // Left: upper half of {dst,src} shifted left by n.
  function automatic logic [DATA_W-1:0] funnel_left(
    input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] s,
    input logic [CNT_W-1:0] n);
    logic [WIDE_W-1:0] w;
    w = {d, s} << n;
    return w[WIDE_W-1:DATA_W];
  endfunction

  // Right: lower half of {src,dst} shifted right by n.
  function automatic logic [DATA_W-1:0] funnel_right(
    input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] s,
    input logic [CNT_W-1:0] n);
    logic [WIDE_W-1:0] w;
    w = {s, d} >> n;
    return w[DATA_W-1:0];
  endfunction

  // Last bit pushed out of the top of the destination: bit (DATA_W - n).
  function automatic logic carry_left(
    input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] n);
    logic [CNT_W:0]  sh;
    logic [DATA_W:0] t;
    sh = FULL - {1'b0, n};
    t  = {1'b0, d} >> sh;
    return t[0];
  endfunction

  // Last bit pushed out of the bottom of the destination: bit (n - 1).
  function automatic logic carry_right(
    input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0]  sh;
    logic [DATA_W-1:0] t;
    sh = n - CNT_W'(1);
    t  = d >> sh;
    return t[0];
  endfunction

  logic [DATA_W-1:0] res_l, res_r;
  logic              cy_l, cy_r;

  always_comb begin
    res_l = funnel_left(dst_i, src_i, cnt_i);
    res_r = funnel_right(dst_i, src_i, cnt_i);
    cy_l  = carry_left(dst_i, cnt_i);
    cy_r  = carry_right(dst_i, cnt_i);
  end

  always_comb begin
    if (dfs_dir_e'(dir_right_i) == DIR_RIGHT) begin
      res_o   = res_r;
      carry_o = cy_r;
    end else begin
      res_o   = res_l;
      carry_o = cy_l;
    end
  end
endmodule

// File: rtl/dfs_flag_gen.sv
module dfs_flag_gen #(
  parameter int DATA_W = 64,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W-1:0]     res_i,
  input  logic [DATA_W-1:0]     dst_i,
  input  logic                  carry_i,
  input  logic                  cnt_one_i,
  input  dfs_pkg::dfs_flags_t   flags_in_i,
  output dfs_pkg::dfs_flags_t   flags_o
);
  import dfs_pkg::*;

  localparam int PW = (PAR_W < DATA_W) ? PAR_W : DATA_W;

  // Even number of ones in the low window gives 1.
  function automatic logic even_parity(input logic [PW-1:0] v);
    return ~(^v);
  endfunction

  logic [PW-1:0] par_win;
  logic          msb_flip;

  generate
    if (PW == DATA_W) begin : g_par_full
      assign par_win = res_i;
    end else begin : g_par_low
      assign par_win = res_i[PW-1:0];
    end
  endgenerate

  assign msb_flip = dst_i[DATA_W-1] ^ res_i[DATA_W-1];

  always_comb begin
    flags_o.cf = carry_i;
    flags_o.of = cnt_one_i ? msb_flip : flags_in_i.of;
    flags_o.zf = (res_i == '0);
    flags_o.sf = res_i[DATA_W-1];
    flags_o.pf = even_parity(par_win);
    flags_o.af = flags_in_i.af;
  end
endmodule

// File: rtl/dfs_unit.sv
module dfs_unit #(
  parameter int DATA_W   = 64,
  parameter int CNT_IN_W = 8,
  parameter int PAR_W    = 8,
  localparam int CNT_W   = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                dir_right_i,
  input  logic                cnt_from_reg_i,
  input  logic [CNT_IN_W-1:0] imm_cnt_i,
  input  logic [CNT_IN_W-1:0] reg_cnt_i,
  input  logic [DATA_W-1:0]   dst_i,
  input  logic [DATA_W-1:0]   src_i,
  input  logic                carry_i,
  input  logic                ovf_i,
  input  logic                zero_i,
  input  logic                sign_i,
  input  logic                parity_i,
  input  logic                aux_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                wr_en_o,
  output logic                carry_o,
  output logic                ovf_o,
  output logic                zero_o,
  output logic                sign_o,
  output logic                parity_o,
  output logic                aux_o,
  output logic                done_o
);
  import dfs_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic [CNT_W-1:0]  eff_cnt;
  logic              cnt_zero;
  logic              cnt_one;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_carry;
  dfs_flags_t        flags_in;
  dfs_flags_t        nxt_flags;
  dfs_flags_t        flags_q;
  logic [DATA_W-1:0] res_q;
  logic              wr_q;
  logic              done_q;

  assign flags_in = '{cf: carry_i, of: ovf_i, zf: zero_i,
                      sf: sign_i, pf: parity_i, af: aux_i};

  dfs_count_sel #(.CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W)) u_cnt (
    .cnt_from_reg_i (cnt_from_reg_i),
    .imm_cnt_i      (imm_cnt_i),
    .reg_cnt_i      (reg_cnt_i),
    .cnt_o          (eff_cnt),
    .cnt_zero_o     (cnt_zero),
    .cnt_one_o      (cnt_one)
  );

  dfs_funnel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_funnel (
    .dir_right_i (dir_right_i),
    .dst_i       (dst_i),
    .src_i       (src_i),
    .cnt_i       (eff_cnt),
    .res_o       (nxt_res),
    .carry_o     (nxt_carry)
  );

  dfs_flag_gen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_flags (
    .res_i      (nxt_res),
    .dst_i      (dst_i),
    .carry_i    (nxt_carry),
    .cnt_one_i  (cnt_one),
    .flags_in_i (flags_in),
    .flags_o    (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= start_i;
      wr_q   <= start_i & ~cnt_zero;
      if (start_i) begin
        if (cnt_zero) begin
          res_q   <= dst_i;
          flags_q <= flags_in;
        end else begin
          res_q   <= nxt_res;
          flags_q <= nxt_flags;
        end
      end
    end
  end

  assign result_o = res_q;
  assign wr_en_o  = wr_q;
  assign done_o   = done_q;
  assign carry_o  = flags_q.cf;
  assign ovf_o    = flags_q.of;
  assign zero_o   = flags_q.zf;
  assign sign_o   = flags_q.sf;
  assign parity_o = flags_q.pf;
  assign aux_o    = flags_q.af;
endmodule

// File: rtl/dfs_unit_chk.sv
module dfs_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cnt_zero,
  input logic              cnt_one,
  input logic              carry_i,
  input logic              ovf_i,
  input logic              zero_i,
  input logic              sign_i,
  input logic              parity_i,
  input logic              aux_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic              carry_o,
  input logic              ovf_o,
  input logic              zero_o,
  input logic              sign_o,
  input logic              parity_o,
  input logic              aux_o,
  input logic              done_o
);
  p_done_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_done_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));

  p_wr_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(carry_o) && $stable(ovf_o)));

  p_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cnt_zero) |=> !wr_en_o);

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cnt_zero) |=> wr_en_o);

  p_noop_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cnt_zero) |=> (carry_o == $past(carry_i) && ovf_o == $past(ovf_i)
      && zero_o == $past(zero_i) && sign_o == $past(sign_i)
      && parity_o == $past(parity_i)));

  p_ovf_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cnt_zero && !cnt_one) |=> (ovf_o == $past(ovf_i)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (zero_o == (result_o == '0)));

  p_sign_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (sign_o == result_o[DATA_W-1]));

  p_aux_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (aux_o == $past(aux_i)));
endmodule

bind dfs_unit dfs_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .cnt_zero (cnt_zero),
  .cnt_one  (cnt_one),
  .carry_i  (carry_i),
  .ovf_i    (ovf_i),
  .zero_i   (zero_i),
  .sign_i   (sign_i),
  .parity_i (parity_i),
  .aux_i    (aux_i),
  .result_o (result_o),
  .wr_en_o  (wr_en_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .zero_o   (zero_o),
  .sign_o   (sign_o),
  .parity_o (parity_o),
  .aux_o    (aux_o),
  .done_o   (done_o)
);

// File: tb/tb_dfs_unit.sv
module tb_dfs_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_right_i = 1'b0;
  logic        cnt_from_reg_i = 1'b0;
  logic [7:0]  imm_cnt_i = '0;
  logic [7:0]  reg_cnt_i = '0;
  logic [63:0] dst_i = '0;
  logic [63:0] src_i = '0;
  logic        carry_i = 1'b0, ovf_i = 1'b0, zero_i = 1'b0;
  logic        sign_i = 1'b0, parity_i = 1'b0, aux_i = 1'b0;
  logic [63:0] result_o;
  logic        wr_en_o, carry_o, ovf_o, zero_o, sign_o, parity_o, aux_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dfs_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_right_i(dir_right_i),
    .cnt_from_reg_i(cnt_from_reg_i), .imm_cnt_i(imm_cnt_i), .reg_cnt_i(reg_cnt_i),
    .dst_i(dst_i), .src_i(src_i), .carry_i(carry_i), .ovf_i(ovf_i),
    .zero_i(zero_i), .sign_i(sign_i), .parity_i(parity_i), .aux_i(aux_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .carry_o(carry_o), .ovf_o(ovf_o),
    .zero_o(zero_o), .sign_o(sign_o), .parity_o(parity_o), .aux_o(aux_o),
    .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Bit-by-bit reference of the funnel result.
  function automatic logic [63:0] ref_shift(input logic right, input logic [63:0] d,
                                            input logic [63:0] s, input int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (!right) r[i] = (i >= n) ? d[i-n] : s[64-n+i];
      else        r[i] = (i + n < 64) ? d[i+n] : s[i+n-64];
    end
    return r;
  endfunction

  function automatic logic ref_even8(input logic [63:0] r);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    return (ones % 2) == 0;
  endfunction

  // Drive one operation, then check every output in the following cycle.
  task automatic run_op(input string name, input logic right, input logic use_reg,
                        input logic [7:0] imm, input logic [7:0] rc,
                        input logic [63:0] d, input logic [63:0] s,
                        input logic [5:0] fin);
    int n;
    logic [63:0] er;
    logic ecf, eof, ezf, esf, epf;
    @(negedge clk);
    dir_right_i = right; cnt_from_reg_i = use_reg; imm_cnt_i = imm; reg_cnt_i = rc;
    dst_i = d; src_i = s;
    {carry_i, ovf_i, zero_i, sign_i, parity_i, aux_i} = fin;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = int'((use_reg ? rc : imm) & 8'h3f);
    if (n == 0) begin
      er = d;
      {ecf, eof, ezf, esf, epf} = fin[5:1];
    end else begin
      er  = ref_shift(right, d, s, n);
      ecf = right ? d[n-1] : d[64-n];
      eof = (n == 1) ? (d[63] != er[63]) : fin[4];
      ezf = (er == 64'd0);
      esf = er[63];
      epf = ref_even8(er);
    end
    chk({name, " R10 done"}, 64'(done_o), 64'd1);
    chk({name, (n == 0) ? " R2 wr_en" : " R10 wr_en"}, 64'(wr_en_o), 64'(n != 0));
    chk({name, (n == 0) ? " R2 result" : (right ? " R4 result" : " R3 result")}, result_o, er);
    chk({name, " R5 carry"}, 64'(carry_o), 64'(ecf));
    chk({name, " R6 ovf"}, 64'(ovf_o), 64'(eof));
    chk({name, " R7 zero"}, 64'(zero_o), 64'(ezf));
    chk({name, " R7 sign"}, 64'(sign_o), 64'(esf));
    chk({name, " R8 parity"}, 64'(parity_o), 64'(epf));
    chk({name, " R9 aux"}, 64'(aux_o), 64'(fin[0]));
    @(negedge clk);
    chk({name, " R10 done pulse ends"}, 64'(done_o), 64'd0);
    chk({name, " R10 result held"}, result_o, er);
  endtask

  task automatic t_reset;
    chk("R11 reset result", result_o, 64'd0);
    chk("R11 reset flags", 64'({wr_en_o, carry_o, ovf_o, zero_o, sign_o, parity_o, aux_o, done_o}), 64'd0);
  endtask

  task automatic t_left_basic;
    run_op("left n=4", 1'b0, 1'b0, 8'd4, 8'd0, 64'hF123_4567_89AB_CDEF, 64'hA000_0000_0000_0000, 6'b000000);
    run_op("left n=63", 1'b0, 1'b0, 8'd63, 8'd0, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFE, 6'b010001);
  endtask

  task automatic t_right_basic;
    run_op("right n=8 reg", 1'b1, 1'b1, 8'd0, 8'd8, 64'h0123_4567_89AB_CD80, 64'h0000_0000_0000_00FF, 6'b000000);
    run_op("right n=63", 1'b1, 1'b0, 8'd63, 8'd0, 64'hC000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0, 6'b010000);
  endtask

  task automatic t_count_select_r1;
    // R1: register source selected, immediate would give a different answer.
    run_op("R1 reg select", 1'b0, 1'b1, 8'd12, 8'd20, 64'h0F0F_0F0F_0F0F_0F0F, 64'h8421_8421_8421_8421, 6'b000000);
    // R1: 0x41 masks to 1 (overflow rule applies).
    run_op("R1 mask 65", 1'b0, 1'b1, 8'd0, 8'h41, 64'h4000_0000_0000_0000, 64'd0, 6'b000000);
  endtask

  task automatic t_noop_r2;
    // R2: 64 masks to 0, flags pass untouched.
    run_op("R2 imm 64", 1'b0, 1'b0, 8'd64, 8'd5, 64'hDEAD_BEEF_0000_1111, 64'hFFFF_FFFF_FFFF_FFFF, 6'b101011);
    run_op("R2 reg 0", 1'b1, 1'b1, 8'd7, 8'd0, 64'h1, 64'h2, 6'b010100);
  endtask

  task automatic t_overflow_r6;
    run_op("R6 right n=1 flip", 1'b1, 1'b0, 8'd1, 8'd0, 64'h0000_0000_0000_0001, 64'h1, 6'b000000);
    run_op("R6 left n=1 same", 1'b0, 1'b0, 8'd1, 8'd0, 64'hC000_0000_0000_0000, 64'h0, 6'b010000);
    run_op("R6 n=2 keeps", 1'b0, 1'b0, 8'd2, 8'd0, 64'h4000_0000_0000_0000, 64'h0, 6'b010000);
  endtask

  task automatic t_zero_result_r7;
    run_op("R7 zero result", 1'b0, 1'b0, 8'd32, 8'd0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 6'b000001);
    run_op("R8 odd parity", 1'b1, 1'b0, 8'd4, 8'd0, 64'h0000_0000_0000_0070, 64'h0, 6'b000000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left_basic();
    t_right_basic();
    t_count_select_r1();
    t_noop_r2();
    t_overflow_r6();
    t_zero_result_r7();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule